// File: doc/BRIEF.md
# Scrambling NRZI Word Serializer

This block turns a stream of 20-bit parallel words into one serial line running at twenty times the word rate. A single bit-rate clock drives everything. An internal modulo-20 counter sets the word period and produces a word clock that the upstream source uses to present its data. The source may be clocked by that word clock directly, in which case its data must come back within one word period. A 2-bit phase select moves the instant at which the parallel word is captured, relative to the word clock. This lets the user trim out the delay of the external data path.

Each captured word is moved into a shifter and sent out least significant bit first. Every bit goes through a self-synchronizing scrambler built on X^9 + X^4 + 1, and then through a transition-on-one (NRZI) encoder built on X + 1. A test output carries the XOR of all bits of each captured word, delayed by two word periods.

The word input has no valid/ready handshake and no back-pressure. The load instant is set by the counter and the phase select, so the source must hold a word stable across the selected capture cycle of every word period. The serial line never stalls.

Top module: `scr_nrzi_ser`

## Requirements
- R1: Every captured word is sent as 20 consecutive serial bits, one per bit clock, bit 0 first. Descrambling the line gives back the captured words unchanged.
- R2: Scrambled bit = shifter bit XOR the scrambled bits sent 4 and 9 bit clocks earlier.
- R3: Line bit = scrambled bit XOR the previous line bit. The line toggles exactly when the scrambled bit is 1.
- R4: The counter steps 0..19 and wraps to 0. `wclk_o` is 1 for counts 0 to 9 and 0 for counts 10 to 19.
- R5: The capture happens at the clock edge that ends count 5*S, where S is the phase select in force. This gives counts 0, 5, 10 or 15 for S = 0, 1, 2, 3. The word present on `word_i` at that edge is the one taken, and no other edge in the period captures.
- R6: `phase_sel_i` is sampled only at the edge that ends count 0. A change at any other time takes effect in the next word period, so each period holds exactly one capture.
- R7: `parity_o` equals the XOR of the 20 bits of word n, starting at capture edge n+2 and lasting until capture edge n+3.
- R8: Synchronous active-high `rst_i` clears the counter, the scrambler history, the NRZI state, the shifter, the hold register and the parity pipe. While reset is held and after it is released, `sdo_o` = 0, `parity_o` = 0 and `wclk_o` = 1. All-zero input words keep `sdo_o` at 0.
- R9: A word captured in period P is moved into the shifter at the edge ending count 19 of P. Its bit k appears on `sdo_o` during count k+1 of period P+1, and bit 19 appears during count 0 of period P+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_i | input | 1 | Synchronous active-high reset |
| word_i | input | WORD_W | Parallel word, taken at the selected capture edge |
| phase_sel_i | input | PH_W | Capture-point select, sampled at the start of a word period |
| wclk_o | output | 1 | Word clock for the upstream source |
| sdo_o | output | 1 | Scrambled, NRZI-encoded serial line |
| parity_o | output | 1 | XOR of a captured word, two word periods late |

## Verification
The bench builds the block with its defaults: WORD_W = 20, PH_W = 2 and a two-period parity delay. This makes every capture offset and every single-bit word position reachable in a few thousand cycles. At each of the four offsets it sends a walking one through all twenty bit positions, then all-zero, all-one and alternating words, then random words. The bench holds each word on the input only during the expected capture cycle and drives its complement everywhere else, so a capture at any other count is exposed. A final run changes the phase select twice in the middle of each word period, which exercises the start-of-period sampling. The serial line is decoded and descrambled arithmetically in the bench and compared word by word.

// File: rtl/snser_pkg.sv
package snser_pkg;
  // Scrambler polynomial X^SCR_LEN + X^SCR_TAP + 1
  localparam int SCR_LEN  = 9;
  localparam int SCR_TAP  = 4;
  // Word periods between capture and parity presentation
  localparam int PAR_DLY  = 2;
endpackage

// File: rtl/snser_timer.sv
module snser_timer #(
  parameter int WORD_W = 20,
  parameter int PH_W   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic [PH_W-1:0]           phase_sel_i,
  output logic [$clog2(WORD_W)-1:0] cnt_o,
  output logic [PH_W-1:0]           phase_q_o,
  output logic                      wclk_o,
  output logic                      load_o,
  output logic                      xfer_o
);
  localparam int CW   = $clog2(WORD_W);
  localparam int OFFS = WORD_W >> PH_W;

  logic [CW-1:0]   cnt_q;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_eff;
  logic [CW-1:0]   load_pt;
  logic            start;

  assign start = (cnt_q == '0);

  // The select is honoured only at the first count of a period
  always_comb ph_eff  = start ? phase_sel_i : ph_q;
  always_comb load_pt = CW'(OFFS * int'(ph_eff));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      ph_q  <= '0;
    end else begin
      cnt_q <= (cnt_q == CW'(WORD_W - 1)) ? '0 : cnt_q + 1'b1;
      if (start) ph_q <= phase_sel_i;
    end
  end

  assign cnt_o     = cnt_q;
  assign phase_q_o = ph_q;
  assign wclk_o    = (cnt_q < CW'(WORD_W / 2));
  assign load_o    = (cnt_q == load_pt);
  assign xfer_o    = (cnt_q == CW'(WORD_W - 1));
endmodule

// File: rtl/snser_path.sv
module snser_path #(
  parameter int WORD_W  = 20,
  parameter int PAR_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              xfer_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o,
  output logic              parity_o
);
  logic [WORD_W-1:0]  hold_q;
  logic [WORD_W-1:0]  shf_q;
  logic [PAR_DLY:0]   par_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_q <= '0;
      par_q  <= '0;
    end else if (load_i) begin
      hold_q <= word_i;
      par_q  <= {par_q[PAR_DLY-1:0], ^word_i};
    end
  end

  // Shifter reloads once per period at a fixed count, independent of phase
  always_ff @(posedge clk_i) begin
    if (rst_i)       shf_q <= '0;
    else if (xfer_i) shf_q <= hold_q;
    else             shf_q <= {1'b0, shf_q[WORD_W-1:1]};
  end

  assign bit_o    = shf_q[0];
  assign parity_o = par_q[PAR_DLY];
endmodule

// File: rtl/snser_scr_nrzi.sv
module snser_scr_nrzi #(
  parameter int LEN = snser_pkg::SCR_LEN,
  parameter int TAP = snser_pkg::SCR_TAP
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bit_i,
  output logic scr_o,
  output logic sdo_o
);
  logic [LEN-1:0] hist_q;   // hist_q[i] = scrambled bit from i+1 clocks ago
  logic           line_q;
  logic           scr;

  assign scr = bit_i ^ hist_q[TAP-1] ^ hist_q[LEN-1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hist_q <= '0;
      line_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[LEN-2:0], scr};
      line_q <= line_q ^ scr;
    end
  end

  assign scr_o = scr;
  assign sdo_o = line_q;
endmodule

// File: rtl/scr_nrzi_ser.sv
module scr_nrzi_ser #(
  parameter int WORD_W  = 20,
  parameter int PH_W    = 2,
  parameter int PAR_DLY = snser_pkg::PAR_DLY,
  parameter int SCR_LEN = snser_pkg::SCR_LEN,
  parameter int SCR_TAP = snser_pkg::SCR_TAP
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [PH_W-1:0]   phase_sel_i,
  output logic              wclk_o,
  output logic              sdo_o,
  output logic              parity_o
);
  localparam int CW = $clog2(WORD_W);

  logic [CW-1:0]   cnt_w;
  logic [PH_W-1:0] ph_q_w;
  logic            load_w;
  logic            xfer_w;
  logic            ser_bit_w;
  logic            scr_bit_w;

  snser_timer #(.WORD_W(WORD_W), .PH_W(PH_W)) u_timer (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .phase_sel_i (phase_sel_i),
    .cnt_o       (cnt_w),
    .phase_q_o   (ph_q_w),
    .wclk_o      (wclk_o),
    .load_o      (load_w),
    .xfer_o      (xfer_w)
  );

  snser_path #(.WORD_W(WORD_W), .PAR_DLY(PAR_DLY)) u_path (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .load_i   (load_w),
    .xfer_i   (xfer_w),
    .word_i   (word_i),
    .bit_o    (ser_bit_w),
    .parity_o (parity_o)
  );

  snser_scr_nrzi #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_line (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .bit_i (ser_bit_w),
    .scr_o (scr_bit_w),
    .sdo_o (sdo_o)
  );
endmodule

// File: rtl/snser_chk.sv
module snser_chk #(
  parameter int WORD_W = 20,
  parameter int PH_W   = 2
) (
  input logic                      clk_i,
  input logic                      rst_i,
  input logic                      wclk_o,
  input logic                      sdo_o,
  input logic                      parity_o,
  input logic [$clog2(WORD_W)-1:0] cnt_i,
  input logic [PH_W-1:0]           ph_q_i,
  input logic                      load_i,
  input logic                      scr_i
);
  localparam int OFFS = WORD_W >> PH_W;

  assert_wclk_rise_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(wclk_o) |-> (cnt_i == '0));

  assert_load_grid_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |-> ((int'(cnt_i) % OFFS) == 0));

  assert_load_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> !load_i);

  assert_phase_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt_i != '0) |=> $stable(ph_q_i));

  assert_line_flip_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    scr_i |=> (sdo_o != $past(sdo_o)));

  assert_line_keep_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    !scr_i |=> $stable(sdo_o));

  assert_reset_clear_R8: assert property (@(posedge clk_i)
    rst_i |=> (!sdo_o && !parity_o && (cnt_i == '0)));
endmodule

bind scr_nrzi_ser snser_chk #(.WORD_W(WORD_W), .PH_W(PH_W)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .wclk_o   (wclk_o),
  .sdo_o    (sdo_o),
  .parity_o (parity_o),
  .cnt_i    (cnt_w),
  .ph_q_i   (ph_q_w),
  .load_i   (load_w),
  .scr_i    (scr_bit_w)
);

// File: tb/test_scr_nrzi_ser.sv
`timescale 1ns/1ps
module test_scr_nrzi_ser;
  localparam int W = 20;

  logic         clk_i = 1'b0;
  logic         rst_i;
  logic [W-1:0] word_i;
  logic [1:0]   phase_sel_i;
  logic         wclk_o, sdo_o, parity_o;

  scr_nrzi_ser i_scr_nrzi_ser (
    .clk_i(clk_i), .rst_i(rst_i), .word_i(word_i), .phase_sel_i(phase_sel_i),
    .wclk_o(wclk_o), .sdo_o(sdo_o), .parity_o(parity_o)
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  int c = 0, ph_m = 0, sel_cur = 0, widx = 0, completions = 0;
  bit zero_mode = 0, mix_mode = 0;
  logic [W-1:0] cur_word = '0, cap_m = '0, xfer_new = '0, xfer_old = '0, rbuf = '0;
  logic [2:0]   pm = '0;
  logic [8:0]   h = '0;
  logic         prev_sdo = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [W-1:0] pick(input int i);
    if (zero_mode) return '0;
    if (i < W) return W'(1) << i;
    case (i)
      20: return '0;
      21: return '1;
      22: return 20'hAAAAA;
      23: return 20'h55555;
      default: return W'($urandom);
    endcase
  endfunction

  // One bit-clock cycle: called at a falling edge, ends at the next one
  task automatic step();
    logic s, d;
    int   eff;
    bit   strobe;
    // R4: word clock level follows the count
    chk(wclk_o == (c < W/2), "R4 wclk_o", 32'(wclk_o), 32'(c < W/2));
    // R7: parity of the word captured two periods before
    chk(parity_o == pm[2], "R7 parity_o", 32'(parity_o), 32'(pm[2]));
    // R8: zero words keep the line quiet
    if (zero_mode) chk(sdo_o == 1'b0, "R8 zero line", 32'(sdo_o), 32'h0);
    // NRZI decode (R3) then descramble (R2)
    s = sdo_o ^ prev_sdo;
    prev_sdo = sdo_o;
    d = s ^ h[3] ^ h[8];
    h = {h[7:0], s};
    rbuf[(c + W - 1) % W] = d;   // R9: bit k seen at count k+1
    if (c == 0) begin
      completions++;
      if (completions > 2)
        chk(rbuf == xfer_old, "R1 R2 R3 R9 recovered word", 32'(rbuf), 32'(xfer_old));
    end
    // Drive inputs; R6: mid-period select changes
    if (mix_mode && c == 3)  sel_cur = (sel_cur + 2) % 4;
    if (mix_mode && c == 10) sel_cur = (sel_cur + 3) % 4;
    phase_sel_i = 2'(sel_cur);
    eff = (c == 0) ? sel_cur : ph_m;
    strobe = (c == eff * 5);   // R5: capture at count 5*S
    if (strobe) begin
      cur_word = pick(widx);
      widx++;
      word_i = cur_word;
    end else begin
      word_i = cur_word ^ '1;   // complement outside the capture cycle
    end
    // Model of the coming rising edge
    if (c == 0) ph_m = sel_cur;
    if (strobe) begin
      cap_m = cur_word;
      pm = {pm[1:0], ^cur_word};
    end
    if (c == W - 1) begin
      xfer_old = xfer_new;
      xfer_new = cap_m;
    end
    c = (c + 1) % W;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "R1 watchdog", 32'h0, 32'h1);
    report();
    $finish;
  end

  initial begin
    rst_i = 1'b1;
    word_i = '0;
    phase_sel_i = 2'd0;
    repeat (4) @(negedge clk_i);
    // R8: state under reset
    chk(sdo_o == 1'b0, "R8 reset sdo_o", 32'(sdo_o), 32'h0);
    chk(parity_o == 1'b0, "R8 reset parity_o", 32'(parity_o), 32'h0);
    chk(wclk_o == 1'b1, "R8 reset wclk_o", 32'(wclk_o), 32'h1);
    rst_i = 1'b0;

    zero_mode = 1;
    repeat (4 * W) step();
    zero_mode = 0;

    for (int ph = 0; ph < 4; ph++) begin
      sel_cur = ph;
      widx = 0;
      repeat (26 * W) step();
    end

    mix_mode = 1;
    repeat (40 * W) step();
    mix_mode = 0;
    sel_cur = 0;
    repeat (4 * W) step();

    report();
    $finish;
  end
endmodule